// File: doc/BRIEF.md
# Link Frame Transmit Scheduler

This block produces the outgoing 32-bit word stream of a serial point-to-point storage link. Each word comes with a 4-bit control-character flag, one bit per byte, and goes to an external 8b/10b encoder and serializer. The host raises two request status bits inside the block through one-cycle set strobes. The acknowledge request sends one short acknowledge frame. The data request sends a burst with a fixed number of data frames. Their payload words are taken from a show-ahead transmit buffer.

Each frame is built in this order: a start delimiter, one header word, the payload words, a CRC-32 word and an end delimiter. The CRC is computed inside the block over the header and the payload. When no frame is in flight, idle ordered-set words fill the line. A frame starts only when the link reports ready and, for data, when the buffer holds a whole payload. Once a frame has started it runs to the end without pause. When a request has been served, its status bit clears and a done pulse is raised.

Top module: `link_tx_sched`

## Requirements
- R1: In every cycle with no frame in flight, the block sends the idle word 0xBC95B5B5 with tx_ctrl_o = 4'b1000. Bit 3 flags byte [31:24]. Payload, header and CRC words carry 4'b0000, and no other flag value ever appears. After reset the output is idle and both pending bits are low.
- R2: A pulse on ack_set_i makes ack_pend_o high one cycle later, and the start delimiter is on the output two cycles after the pulse. The acknowledge frame is exactly: 0xBCB55757 (flag 4'b1000), header 0xC1000000, the CRC word, then 0xBC95D5D5 (flag 4'b1000).
- R3: A pending acknowledge is chosen before the start of any new data frame, including between two frames of a burst. It is never placed inside a frame.
- R4: A pulse on data_set_i raises data_pend_o and sends BURST_FRAMES data frames. Each frame is: the start delimiter, header 0xD20000nn with nn the frame index 0..BURST_FRAMES-1, PAYLOAD_WORDS payload words, the CRC word and the end delimiter. The next start delimiter follows an end delimiter directly when the next frame may start.
- R5: Payload words are buf_rdata_i, sent in buffer order, one buf_pop_o per payload word.
- R6: The CRC word is the bitwise inverse of a CRC-32 over the header and payload words. The CRC uses polynomial 0x04C11DB7, seed 0xFFFFFFFF and no reflection, and takes each word bit 31 first.
- R7: A data frame starts only while buf_count_i >= PAYLOAD_WORDS. Otherwise idles continue and nothing is popped.
- R8: No frame starts in a cycle with ready_i low. A frame already started completes whatever ready_i does.
- R9: ack_done_o, or burst_done_o after the last frame of a burst, pulses for one cycle together with that frame's end delimiter. In the same cycle the matching pending bit falls.
- R10: A set strobe that arrives while its pending bit is high is ignored. It sends no extra frame and does not restart the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_set_i | input | 1 | Strobe that requests one acknowledge frame |
| data_set_i | input | 1 | Strobe that requests one data burst |
| ready_i | input | 1 | Link may start a frame |
| buf_count_i | input | CNT_W | Words held in the transmit buffer |
| buf_rdata_i | input | 32 | Head word of the transmit buffer (show-ahead) |
| buf_pop_o | output | 1 | Consume the head word this cycle |
| tx_data_o | output | 32 | Outgoing word |
| tx_ctrl_o | output | 4 | Control-character flag per byte, bit 3 = byte [31:24] |
| ack_pend_o | output | 1 | Acknowledge request pending |
| data_pend_o | output | 1 | Data burst request pending |
| ack_done_o | output | 1 | Acknowledge frame finished |
| burst_done_o | output | 1 | Data burst finished |

## Verification
The hardest case to reach is an acknowledge request that lands while a burst is under way. The acknowledge must then appear between two data frames, never inside one, and the frame indices of the burst must carry on unchanged afterwards. The bench gets there by waiting for the start delimiter of the first data frame and pulsing the acknowledge and data strobes inside that frame. It then checks the exact order of the frames. Random phases toggle ready and starve the buffer so that frames start at uneven points. Every frame is parsed on the fly, and its header, payload and CRC are checked against bench models.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PAY,
        ST_CRC,
        ST_EOF
    } lts_state_e;

    typedef enum logic {
        FK_ACK,
        FK_DATA
    } lts_kind_e;

    localparam logic [31:0] W_IDLE = 32'hBC95B5B5;
    localparam logic [31:0] W_SOF  = 32'hBCB55757;
    localparam logic [31:0] W_EOF  = 32'hBC95D5D5;
    localparam logic [3:0]  K_LEAD = 4'b1000;
    localparam logic [3:0]  K_NONE = 4'b0000;

    localparam logic [7:0]  TYPE_ACK  = 8'hC1;
    localparam logic [7:0]  TYPE_DATA = 8'hD2;

    localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

endpackage

// File: rtl/lts_crc32.sv
module lts_crc32 #(
    parameter logic [31:0] POLY = 32'h04C11DB7
) (
    input  logic [31:0] crc_i,
    input  logic [31:0] word_i,
    output logic [31:0] crc_o
);

    // One whole word per call, bit 31 enters first, no reflection.
    always_comb begin
        logic [31:0] acc;
        logic        fb;
        acc = crc_i;
        for (int b = 31; b >= 0; b--) begin
            fb  = acc[31] ^ word_i[b];
            acc = {acc[30:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc_o = acc;
    end

endmodule

// File: rtl/lts_req_flag.sv
module lts_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);

    logic pend_d, pend_q;

    // A set while already pending is dropped; clear wins over nothing else.
    always_comb begin
        pend_d = pend_q;
        if (pend_q && clr_i) begin
            pend_d = 1'b0;
        end else if (!pend_q && set_i) begin
            pend_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign pend_o = pend_q;

    // R9: the scheduler only retires a request that is really pending
    p_clr_when_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |-> pend_q);

    // R10: a strobe during a pending request cannot drop it
    p_set_keeps_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);

endmodule

// File: rtl/link_tx_sched.sv
module link_tx_sched
    import lts_pkg::*;
#(
    parameter int PAYLOAD_WORDS = 4,
    parameter int BURST_FRAMES  = 3,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_set_i,
    input  logic             data_set_i,
    input  logic             ready_i,
    input  logic [CNT_W-1:0] buf_count_i,
    input  logic [31:0]      buf_rdata_i,
    output logic             buf_pop_o,
    output logic [31:0]      tx_data_o,
    output logic [3:0]       tx_ctrl_o,
    output logic             ack_pend_o,
    output logic             data_pend_o,
    output logic             ack_done_o,
    output logic             burst_done_o
);

    localparam int PW_W = $clog2(PAYLOAD_WORDS + 1);
    localparam int BF_W = $clog2(BURST_FRAMES + 1);
    localparam logic [CNT_W-1:0] NEED_WORDS = CNT_W'(PAYLOAD_WORDS);
    localparam logic [PW_W-1:0]  LAST_PAY   = PW_W'(PAYLOAD_WORDS - 1);
    localparam logic [BF_W-1:0]  LAST_FRM   = BF_W'(BURST_FRAMES - 1);

    typedef struct packed {
        lts_state_e      st;
        lts_kind_e       kind;
        logic [PW_W-1:0] pay_cnt;
        logic [BF_W-1:0] frm_idx;
        logic [31:0]     crc;
        logic [31:0]     tx_data;
        logic [3:0]      tx_ctrl;
        logic            ack_done;
        logic            burst_done;
    } sched_t;

    localparam sched_t SCHED_RST = '{
        st:         ST_IDLE,
        kind:       FK_ACK,
        pay_cnt:    '0,
        frm_idx:    '0,
        crc:        CRC_SEED,
        tx_data:    W_IDLE,
        tx_ctrl:    K_LEAD,
        ack_done:   1'b0,
        burst_done: 1'b0
    };

    sched_t      sch_d, sch_q;
    logic        ack_pend, data_pend;
    logic        ack_clr, data_clr;
    logic        pop;
    logic [31:0] hdr_word;
    logic [31:0] crc_in, crc_word, crc_next;
    logic        can_ack, can_data;

    // Request flags (status bits)
    lts_req_flag u_ack_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ack_set_i),
        .clr_i  (ack_clr),
        .pend_o (ack_pend)
    );

    lts_req_flag u_data_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (data_set_i),
        .clr_i  (data_clr),
        .pend_o (data_pend)
    );

    // Header and CRC operand selection
    always_comb begin
        if (sch_q.kind == FK_ACK) begin
            hdr_word = {TYPE_ACK, 16'h0000, 8'h00};
        end else begin
            hdr_word = {TYPE_DATA, 16'h0000, 8'(sch_q.frm_idx)};
        end
        if (sch_q.st == ST_HDR) begin
            crc_in   = CRC_SEED;
            crc_word = hdr_word;
        end else begin
            crc_in   = sch_q.crc;
            crc_word = buf_rdata_i;
        end
    end

    lts_crc32 #(
        .POLY (CRC_POLY)
    ) u_crc (
        .crc_i  (crc_in),
        .word_i (crc_word),
        .crc_o  (crc_next)
    );

    assign can_ack  = ready_i && ack_pend;
    assign can_data = ready_i && data_pend && (buf_count_i >= NEED_WORDS);

    // Next-state logic
    always_comb begin
        sch_d            = sch_q;
        sch_d.tx_data    = W_IDLE;
        sch_d.tx_ctrl    = K_LEAD;
        sch_d.ack_done   = 1'b0;
        sch_d.burst_done = 1'b0;
        ack_clr          = 1'b0;
        data_clr         = 1'b0;
        pop              = 1'b0;

        case (sch_q.st)
            ST_IDLE: begin
                if (can_ack) begin
                    sch_d.kind    = FK_ACK;
                    sch_d.st      = ST_HDR;
                    sch_d.tx_data = W_SOF;
                end else if (can_data) begin
                    sch_d.kind    = FK_DATA;
                    sch_d.st      = ST_HDR;
                    sch_d.tx_data = W_SOF;
                end
            end
            ST_HDR: begin
                sch_d.tx_data = hdr_word;
                sch_d.tx_ctrl = K_NONE;
                sch_d.crc     = crc_next;
                sch_d.pay_cnt = '0;
                sch_d.st      = (sch_q.kind == FK_ACK) ? ST_CRC : ST_PAY;
            end
            ST_PAY: begin
                pop           = 1'b1;
                sch_d.tx_data = buf_rdata_i;
                sch_d.tx_ctrl = K_NONE;
                sch_d.crc     = crc_next;
                if (sch_q.pay_cnt == LAST_PAY) begin
                    sch_d.st = ST_CRC;
                end else begin
                    sch_d.pay_cnt = sch_q.pay_cnt + 1'b1;
                end
            end
            ST_CRC: begin
                sch_d.tx_data = ~sch_q.crc;
                sch_d.tx_ctrl = K_NONE;
                sch_d.st      = ST_EOF;
            end
            ST_EOF: begin
                sch_d.tx_data = W_EOF;
                sch_d.st      = ST_IDLE;
                if (sch_q.kind == FK_ACK) begin
                    ack_clr        = 1'b1;
                    sch_d.ack_done = 1'b1;
                end else if (sch_q.frm_idx == LAST_FRM) begin
                    data_clr         = 1'b1;
                    sch_d.burst_done = 1'b1;
                    sch_d.frm_idx    = '0;
                end else begin
                    sch_d.frm_idx = sch_q.frm_idx + 1'b1;
                end
            end
            default: begin
                sch_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sch_q <= SCHED_RST;
        end else begin
            sch_q <= sch_d;
        end
    end

    assign buf_pop_o    = pop;
    assign tx_data_o    = sch_q.tx_data;
    assign tx_ctrl_o    = sch_q.tx_ctrl;
    assign ack_pend_o   = ack_pend;
    assign data_pend_o  = data_pend;
    assign ack_done_o   = sch_q.ack_done;
    assign burst_done_o = sch_q.burst_done;

    // R1: only the lead byte can ever be flagged
    p_ctrl_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl_o == K_NONE) || (tx_ctrl_o == K_LEAD));

    // R3: a pending acknowledge wins the frame start
    p_ack_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sch_q.st == ST_HDR && $past(ack_pend)) |-> (sch_q.kind == FK_ACK));

    // R7: the buffer is never drained below empty
    p_pop_has_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_pop_o |-> (buf_count_i != '0));

    // R8: a start delimiter needs ready in the deciding cycle
    p_sof_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ctrl_o == K_LEAD && tx_data_o == W_SOF) |-> $past(ready_i));

    // R9: done pulses ride on the end delimiter, never together
    p_done_on_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done_o || burst_done_o) |-> (tx_data_o == W_EOF && tx_ctrl_o == K_LEAD));

    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_done_o && burst_done_o));

    p_ack_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_pend_o) |-> ack_done_o);

endmodule

// File: tb/sim_link_tx_sched.sv
module sim_link_tx_sched;

    localparam int P  = 4;
    localparam int B  = 3;
    localparam int CW = 8;

    localparam logic [31:0] IDLE_W = 32'hBC95B5B5;
    localparam logic [31:0] SOF_W  = 32'hBCB55757;
    localparam logic [31:0] EOF_W  = 32'hBC95D5D5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ack_set = 1'b0, data_set = 1'b0, ready = 1'b1;
    logic [CW-1:0] buf_count = '0;
    logic [31:0]   buf_rdata = '0;
    logic          buf_pop;
    logic [31:0]   tx_data;
    logic [3:0]    tx_ctrl;
    logic          ack_pend, data_pend, ack_done, burst_done;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    link_tx_sched #(.PAYLOAD_WORDS(P), .BURST_FRAMES(B), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .ack_set_i(ack_set), .data_set_i(data_set),
        .ready_i(ready), .buf_count_i(buf_count), .buf_rdata_i(buf_rdata),
        .buf_pop_o(buf_pop), .tx_data_o(tx_data), .tx_ctrl_o(tx_ctrl),
        .ack_pend_o(ack_pend), .data_pend_o(data_pend),
        .ack_done_o(ack_done), .burst_done_o(burst_done));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] w);
        for (int i = 31; i >= 0; i--) begin
            logic fb;
            fb = c[31] ^ w[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction

    // Show-ahead buffer model
    logic [31:0] fifo_q[$];
    logic [31:0] exp_pay[$];
    int          pushed = 0;
    bit          pop_flag = 0;

    task automatic push_word(input logic [31:0] w);
        fifo_q.push_back(w);
        exp_pay.push_back(w);
        pushed++;
    endtask

    always @(negedge clk) begin
        if (pop_flag && fifo_q.size() > 0) void'(fifo_q.pop_front());
        buf_count = CW'(fifo_q.size());
        buf_rdata = (fifo_q.size() > 0) ? fifo_q[0] : 32'h0;
        pop_flag  = buf_pop;
    end

    // Stream monitor and frame parser
    bit          in_frame = 0;
    logic [31:0] fr[$];
    int          sof_cnt = 0, ack_frames = 0, data_frames = 0, bursts = 0;
    int          exp_seq = 0;
    bit          strict_b2b = 0, want_sof = 0;
    logic [7:0]  types_q[$];

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_ctrl != 4'b0000 && tx_ctrl != 4'b1000)
                chk(0, "R1", "illegal ctrl flag", 32'(tx_ctrl), 32'h8);
            if ((ack_done || burst_done) && !(tx_ctrl == 4'b1000 && tx_data == EOF_W))
                chk(0, "R9", "done pulse off end delimiter", tx_data, EOF_W);
            if (want_sof) begin
                chk(tx_ctrl == 4'b1000 && tx_data == SOF_W, "R4", "gap between burst frames", tx_data, SOF_W);
                want_sof = 0;
            end
            if (tx_ctrl == 4'b1000) begin
                if (tx_data == SOF_W) begin
                    if (in_frame) chk(0, "R3", "start inside frame", tx_data, EOF_W);
                    in_frame = 1; fr.delete(); sof_cnt++;
                end else if (tx_data == EOF_W) begin
                    if (!in_frame) chk(0, "R4", "stray end delimiter", tx_data, IDLE_W);
                    else check_frame();
                    in_frame = 0;
                end else if (tx_data == IDLE_W) begin
                    if (in_frame) chk(0, "R8", "idle inside frame", tx_data, 32'h0);
                end else begin
                    chk(0, "R1", "unknown control word", tx_data, IDLE_W);
                end
            end else if (tx_ctrl == 4'b0000) begin
                if (!in_frame) chk(0, "R1", "data word outside frame", tx_data, IDLE_W);
                else fr.push_back(tx_data);
            end
        end
    end

    task automatic check_frame();
        logic [31:0] c;
        logic [31:0] w;
        int n;
        n = fr.size();
        c = 32'hFFFFFFFF;
        if (n < 2) begin
            chk(0, "R4", "frame too short", 32'(n), 32'(P + 2));
            return;
        end
        types_q.push_back(fr[0][31:24]);
        for (int i = 0; i < n - 1; i++) c = crc_upd(c, fr[i]);
        chk(fr[n-1] == ~c, "R6", "crc word", fr[n-1], ~c);
        if (fr[0][31:24] == 8'hC1) begin
            ack_frames++;
            chk(n == 2, "R2", "ack frame length", 32'(n), 32'd2);
            chk(fr[0] == 32'hC1000000, "R2", "ack header", fr[0], 32'hC1000000);
            chk(ack_done && !burst_done, "R9", "ack done pulse", {ack_done, burst_done}, 32'h2);
            chk(!ack_pend, "R9", "ack pending cleared", 32'(ack_pend), 32'h0);
        end else begin
            data_frames++;
            chk(n == P + 2, "R4", "data frame length", 32'(n), 32'(P + 2));
            chk(fr[0] == {8'hD2, 16'h0, 8'(exp_seq)}, "R4", "data header", fr[0], {8'hD2, 16'h0, 8'(exp_seq)});
            for (int i = 1; i < n - 1; i++) begin
                w = (exp_pay.size() > 0) ? exp_pay.pop_front() : 32'hDEADDEAD;
                chk(fr[i] == w, "R5", "payload word", fr[i], w);
            end
            exp_seq++;
            if (exp_seq == B) begin
                exp_seq = 0; bursts++;
                chk(burst_done && !ack_done, "R9", "burst done pulse", {ack_done, burst_done}, 32'h1);
                chk(!data_pend, "R9", "data pending cleared", 32'(data_pend), 32'h0);
            end else begin
                chk(!burst_done, "R9", "early burst done", 32'(burst_done), 32'h0);
                if (strict_b2b) want_sof = 1;
            end
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack_set = 1; tick(1); ack_set = 0;
    endtask

    task automatic pulse_data();
        data_set = 1; tick(1); data_set = 0;
    endtask

    task automatic wait_quiet();
        int k;
        k = 0;
        tick(2);
        while ((ack_pend || data_pend || in_frame) && k < 5000) begin
            tick(1); k++;
        end
        tick(2);
        chk(k < 5000, "R4", "requests drained", 32'(k), 32'h0);
    endtask

    int acks_ok = 0, datas_ok = 0;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=%0d exp=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int a0, d0, b0, s0;
        void'($urandom(32'd8121));
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk(tx_data == IDLE_W && tx_ctrl == 4'b1000, "R1", "idle after reset", tx_data, IDLE_W);
        chk(!ack_pend && !data_pend && !buf_pop, "R1", "pending low after reset", {ack_pend, data_pend, buf_pop}, 32'h0);

        // R2 acknowledge timing and content
        a0 = ack_frames;
        ack_set = 1; tick(1); ack_set = 0;
        chk(ack_pend, "R2", "pending one cycle after set", 32'(ack_pend), 32'h1);
        tick(1);
        chk(tx_data == SOF_W && tx_ctrl == 4'b1000, "R2", "start two cycles after set", tx_data, SOF_W);
        wait_quiet();
        chk(ack_frames == a0 + 1, "R2", "one ack frame", 32'(ack_frames), 32'(a0 + 1));

        // R7 short buffer holds the burst
        s0 = sof_cnt; d0 = data_frames;
        for (int i = 0; i < P - 2; i++) push_word($urandom());
        pulse_data();
        tick(30);
        chk(sof_cnt == s0, "R7", "no frame with short buffer", 32'(sof_cnt), 32'(s0));
        chk(buf_count == CW'(P - 2), "R7", "nothing popped", 32'(buf_count), 32'(P - 2));
        chk(data_pend, "R7", "request still pending", 32'(data_pend), 32'h1);
        strict_b2b = 1;
        for (int i = 0; i < P * B - (P - 2); i++) push_word($urandom());
        wait_quiet();
        strict_b2b = 0;
        chk(data_frames == d0 + B, "R4", "burst frame count", 32'(data_frames), 32'(d0 + B));

        // R8 + R3: both requests while not ready, ack must lead
        ready = 0;
        for (int i = 0; i < P * B; i++) push_word($urandom());
        s0 = sof_cnt;
        types_q.delete();
        ack_set = 1; data_set = 1; tick(1); ack_set = 0; data_set = 0;
        tick(12);
        chk(sof_cnt == s0, "R8", "no start while not ready", 32'(sof_cnt), 32'(s0));
        ready = 1;
        wait_quiet();
        chk(types_q.size() == B + 1 && types_q[0] == 8'hC1, "R3", "ack sent before burst", 32'(types_q[0]), 32'hC1);

        // R3 + R10: ack and repeated strobes inside the first data frame
        for (int i = 0; i < P * B; i++) push_word($urandom());
        types_q.delete();
        a0 = ack_frames; b0 = bursts; s0 = sof_cnt;
        pulse_data();
        while (sof_cnt == s0) tick(1);
        pulse_ack(); pulse_data(); pulse_ack();
        wait_quiet();
        chk(types_q.size() == B + 1, "R10", "frame total with extra strobes", 32'(types_q.size()), 32'(B + 1));
        chk(types_q[0] == 8'hD2 && types_q[1] == 8'hC1 && types_q[2] == 8'hD2, "R3", "ack between burst frames",
            {types_q[0], types_q[1], types_q[2]}, 32'hD2C1D2);
        chk(ack_frames == a0 + 1, "R10", "single ack for repeated strobe", 32'(ack_frames), 32'(a0 + 1));
        chk(bursts == b0 + 1, "R10", "single burst for repeated strobe", 32'(bursts), 32'(b0 + 1));

        // R8 ready dropped inside a frame
        a0 = ack_frames; s0 = sof_cnt;
        pulse_ack();
        while (sof_cnt == s0) tick(1);
        ready = 0;
        tick(10);
        chk(ack_frames == a0 + 1, "R8", "frame completes after ready drop", 32'(ack_frames), 32'(a0 + 1));
        ready = 1;
        wait_quiet();

        // Random phase
        a0 = ack_frames; b0 = bursts;
        for (int i = 0; i < 3000; i++) begin
            ready = ($urandom_range(0, 9) < 8);
            if ($urandom_range(0, 99) < 4) begin
                if (!ack_pend) acks_ok++;
                ack_set = 1;
            end
            if ($urandom_range(0, 99) < 3) begin
                if (!data_pend) datas_ok++;
                data_set = 1;
            end
            if ($urandom_range(0, 1) == 1 && fifo_q.size() < 200) push_word($urandom());
            tick(1);
            ack_set = 0; data_set = 0;
        end
        ready = 1;
        for (int i = 0; i < P * B; i++) push_word($urandom());
        wait_quiet();
        chk(ack_frames - a0 == acks_ok, "R10", "random ack count", 32'(ack_frames - a0), 32'(acks_ok));
        chk(bursts - b0 == datas_ok, "R4", "random burst count", 32'(bursts - b0), 32'(datas_ok));
        chk(fifo_q.size() == pushed - P * data_frames, "R5", "words consumed", 32'(fifo_q.size()),
            32'(pushed - P * data_frames));
        chk(tx_data == IDLE_W && tx_ctrl == 4'b1000, "R1", "idle when quiet", tx_data, IDLE_W);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule